// File: doc/BRIEF.md
# Genetic path optimisation engine

This block runs a generational genetic search over a population of binary chromosomes held in on-chip registers. Each chromosome encodes one candidate path, and its bit fields stand for waypoint positions. The block does not compute fitness. For each member it raises a request that carries the member's index and bit string, and it takes back the estimated path distance on a response input. The smallest distance seen so far, and the chromosome that produced it, are kept as the best result.

Between evaluations the block breeds a full replacement generation. For each pair of offspring it draws two parents at random from the current population and cuts both at one random point, so that each child keeps its own parent's low bits and takes the other parent's high bits. It then inverts one random bit of each child with a programmable probability. All random draws come from a 16-bit maximal-length LFSR whose seed is loaded through a port. A run evaluates a programmed number of generations and then raises `done_o`. The best chromosome is the reference trajectory handed to the path follower.

Top module: `ga_path_engine`

## Requirements
- R1: After reset the block is idle: `busy_o`=0, `done_o`=0, `fit_req_o`=0, `best_dist_o` is all ones and `best_chrom_o` is zero.
- R2: While idle, `init_we_i` writes `init_chrom_i` into population slot `init_idx_i`. The first evaluation pass of a run presents slots 0 to POP-1 in ascending order, each with the value that was loaded.
- R3: `fit_req_o` stays high, with `fit_idx_o` and `fit_chrom_o` stable, until a cycle in which `fit_ack_i` is high. A run with `num_gen_i`=G issues exactly POP×G accepted requests. G=0 finishes with no request.
- R4: A run first sets the best distance to all ones. The best result is replaced only by a strictly smaller accepted distance, so among equal distances the earliest one is kept.
- R5: With `mut_rate_i`=0, every bit of every offspring equals the same bit of at least one of its two parents. A bit column that is common to the whole population therefore persists across generations, and a uniform population stays uniform.
- R6: Each child is mutated when a 4-bit random value is below `mut_rate_i` (range 0 to 16, so 16 means always). A mutated child differs from its crossover result in exactly one bit.
- R7: Offspring replace the entire population. With a uniform population X and `mut_rate_i`=16, every member of the second generation differs from X in exactly one bit.
- R8: `busy_o` rises in the cycle after `start_i` is accepted. `done_o` rises when the last response of the final generation is accepted and holds until the next start. `start_i` has no effect while busy.
- R9: `seed_load_i` loads `seed_i` into the LFSR while idle, and a zero seed is replaced by 1. The LFSR uses x^16+x^14+x^13+x^11+1 and steps only while busy. The same seed, population and response timing reproduce the same request sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seed_load_i | input | 1 | Load LFSR seed (idle only) |
| seed_i | input | 16 | LFSR seed value |
| init_we_i | input | 1 | Population write strobe (idle only) |
| init_idx_i | input | IW | Population slot to write |
| init_chrom_i | input | CW | Chromosome to write |
| start_i | input | 1 | Start a run |
| num_gen_i | input | GW | Number of generations to evaluate |
| mut_rate_i | input | 5 | Mutation probability in sixteenths (0..16) |
| fit_req_o | output | 1 | Fitness request pending |
| fit_idx_o | output | IW | Index of the member under evaluation |
| fit_chrom_o | output | CW | Chromosome under evaluation |
| fit_ack_i | input | 1 | Fitness response valid |
| fit_dist_i | input | DW | Estimated path distance |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, result valid |
| best_chrom_o | output | CW | Shortest-distance chromosome seen |
| best_dist_o | output | DW | Its distance |

## Verification
The hardest thing to reach from the ports is bred offspring whose content is predictable, because every parent pick, cut point and flipped bit comes from the internal LFSR. The bench uses populations that make the answer independent of the draws. A population with a shared byte and mutation off must keep that byte in every later generation. A uniform population with mutation forced to always must yield a second generation in which every member is exactly one bit away from the original. The fitness responder inserts wait cycles to test that requests hold steady, and it uses one distance for every member to show that ties keep the earliest result. Reproducibility, and the substitution of 1 for a zero seed, are shown by comparing whole request logs from repeated runs.

// File: rtl/ga_pkg.sv
package ga_pkg;
  localparam int unsigned LFSR_W = 16;

  typedef enum logic [2:0] {
    S_IDLE,
    S_EVAL,
    S_PICK,
    S_MATE,
    S_SWAP
  } ga_state_e;
endpackage

// File: rtl/ga_lfsr.sv
module ga_lfsr
  import ga_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LFSR_W-1:0] seed_i,
  input  logic              step_i,
  output logic [LFSR_W-1:0] state_o
);
  logic [LFSR_W-1:0] q;
  logic              fb;

  // x^16 + x^14 + x^13 + x^11 + 1
  assign fb = q[15] ^ q[13] ^ q[12] ^ q[10];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= LFSR_W'(1);
    else if (load_i)  q <= (seed_i == '0) ? LFSR_W'(1) : seed_i;
    else if (step_i)  q <= {q[LFSR_W-2:0], fb};
  end

  assign state_o = q;

  p_lfsr_live_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q != '0);
endmodule

// File: rtl/ga_mate.sv
module ga_mate #(
  parameter int unsigned CW = 16,
  localparam int unsigned BW = $clog2(CW)
) (
  input  logic [CW-1:0] pa_i,
  input  logic [CW-1:0] pb_i,
  input  logic [BW-1:0] cut_i,
  input  logic [4:0]    rate_i,
  input  logic [3:0]    roll0_i,
  input  logic [BW-1:0] pos0_i,
  input  logic [3:0]    roll1_i,
  input  logic [BW-1:0] pos1_i,
  output logic [CW-1:0] c0_o,
  output logic [CW-1:0] c1_o
);
  logic [CW-1:0] one, low, x0, x1, f0, f1;
  logic          m0, m1;

  always_comb begin
    one = CW'(1);
    low = (one << cut_i) - one;
    // low part stays with its own parent, tail is swapped
    x0  = (pa_i & low) | (pb_i & ~low);
    x1  = (pb_i & low) | (pa_i & ~low);
    m0  = {1'b0, roll0_i} < rate_i;
    m1  = {1'b0, roll1_i} < rate_i;
    f0  = m0 ? (one << pos0_i) : '0;
    f1  = m1 ? (one << pos1_i) : '0;
    c0_o = x0 ^ f0;
    c1_o = x1 ^ f1;
  end
endmodule

// File: rtl/ga_best.sv
module ga_best #(
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          upd_i,
  input  logic [CW-1:0] chrom_i,
  input  logic [DW-1:0] dist_i,
  output logic [CW-1:0] best_chrom_o,
  output logic [DW-1:0] best_dist_o
);
  logic [CW-1:0] chrom_q;
  logic [DW-1:0] dist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chrom_q <= '0;
      dist_q  <= '1;
    end else if (clr_i) begin
      chrom_q <= '0;
      dist_q  <= '1;
    end else if (upd_i && (dist_i < dist_q)) begin
      chrom_q <= chrom_i;
      dist_q  <= dist_i;
    end
  end

  assign best_chrom_o = chrom_q;
  assign best_dist_o  = dist_q;

  p_best_monotone_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> dist_q <= $past(dist_q));
endmodule

// File: rtl/ga_path_engine.sv
module ga_path_engine
  import ga_pkg::*;
#(
  parameter int unsigned POP = 8,
  parameter int unsigned CW  = 16,
  parameter int unsigned DW  = 16,
  parameter int unsigned GW  = 8,
  localparam int unsigned IW    = $clog2(POP),
  localparam int unsigned BW    = $clog2(CW),
  localparam int unsigned PAIRS = POP / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seed_load_i,
  input  logic [LFSR_W-1:0] seed_i,
  input  logic              init_we_i,
  input  logic [IW-1:0]     init_idx_i,
  input  logic [CW-1:0]     init_chrom_i,
  input  logic              start_i,
  input  logic [GW-1:0]     num_gen_i,
  input  logic [4:0]        mut_rate_i,
  output logic              fit_req_o,
  output logic [IW-1:0]     fit_idx_o,
  output logic [CW-1:0]     fit_chrom_o,
  input  logic              fit_ack_i,
  input  logic [DW-1:0]     fit_dist_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CW-1:0]     best_chrom_o,
  output logic [DW-1:0]     best_dist_o
);
  ga_state_e         state_q;
  logic [CW-1:0]     pop_q [POP];
  logic [CW-1:0]     nxt_q [POP];
  logic [IW-1:0]     idx_q, pair_q, pa_q, pb_q;
  logic [BW-1:0]     cut_q;
  logic [GW-1:0]     gen_left_q;
  logic [4:0]        rate_q;
  logic              done_q;
  logic [LFSR_W-1:0] rnd;
  logic [CW-1:0]     c0, c1;
  logic              idle, go, take;
  logic [IW-1:0]     slot0, slot1;

  assign idle  = (state_q == S_IDLE);
  assign go    = idle && start_i;
  assign take  = (state_q == S_EVAL) && fit_ack_i;
  assign slot0 = IW'(pair_q << 1);
  assign slot1 = slot0 | IW'(1);

  ga_lfsr u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (idle && seed_load_i),
    .seed_i  (seed_i),
    .step_i  (!idle),
    .state_o (rnd)
  );

  ga_mate #(.CW(CW)) u_mate (
    .pa_i    (pop_q[pa_q]),
    .pb_i    (pop_q[pb_q]),
    .cut_i   (cut_q),
    .rate_i  (rate_q),
    .roll0_i (rnd[3:0]),
    .pos0_i  (rnd[4 +: BW]),
    .roll1_i (rnd[11:8]),
    .pos1_i  (rnd[12 +: BW]),
    .c0_o    (c0),
    .c1_o    (c1)
  );

  ga_best #(.CW(CW), .DW(DW)) u_best (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (go),
    .upd_i        (take),
    .chrom_i      (pop_q[idx_q]),
    .dist_i       (fit_dist_i),
    .best_chrom_o (best_chrom_o),
    .best_dist_o  (best_dist_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      idx_q      <= '0;
      pair_q     <= '0;
      pa_q       <= '0;
      pb_q       <= '0;
      cut_q      <= '0;
      gen_left_q <= '0;
      rate_q     <= '0;
      done_q     <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          done_q     <= (num_gen_i == '0);
          gen_left_q <= num_gen_i;
          rate_q     <= mut_rate_i;
          idx_q      <= '0;
          if (num_gen_i != '0) state_q <= S_EVAL;
        end
        S_EVAL: if (fit_ack_i) begin
          if (idx_q == IW'(POP-1)) begin
            idx_q <= '0;
            if (gen_left_q == GW'(1)) begin
              state_q <= S_IDLE;
              done_q  <= 1'b1;
            end else begin
              gen_left_q <= gen_left_q - GW'(1);
              pair_q     <= '0;
              state_q    <= S_PICK;
            end
          end else begin
            idx_q <= idx_q + IW'(1);
          end
        end
        S_PICK: begin
          pa_q    <= rnd[IW-1:0];
          pb_q    <= rnd[8 +: IW];
          cut_q   <= rnd[4 +: BW];
          state_q <= S_MATE;
        end
        S_MATE: begin
          if (pair_q == IW'(PAIRS-1)) state_q <= S_SWAP;
          else begin
            pair_q  <= pair_q + IW'(1);
            state_q <= S_PICK;
          end
        end
        S_SWAP: state_q <= S_EVAL;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < POP; i++) begin
        pop_q[i] <= '0;
        nxt_q[i] <= '0;
      end
    end else begin
      if (idle && init_we_i) pop_q[init_idx_i] <= init_chrom_i;
      if (state_q == S_MATE) begin
        nxt_q[slot0] <= c0;
        nxt_q[slot1] <= c1;
      end
      if (state_q == S_SWAP) begin
        for (int i = 0; i < POP; i++) pop_q[i] <= nxt_q[i];
      end
    end
  end

  assign fit_req_o   = (state_q == S_EVAL);
  assign fit_idx_o   = idx_q;
  assign fit_chrom_o = pop_q[idx_q];
  assign busy_o      = !idle;
  assign done_o      = done_q;

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fit_req_o && !fit_ack_i |=> fit_req_o && $stable(fit_idx_o) && $stable(fit_chrom_o));

  p_done_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !fit_req_o);

  p_mix_from_parents_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_MATE) && (rate_q == 5'd0) |->
      (((c0 ^ pop_q[pa_q]) & (c0 ^ pop_q[pb_q])) == '0) &&
      (((c1 ^ pop_q[pa_q]) & (c1 ^ pop_q[pb_q])) == '0));

  p_flip_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_MATE) && (pa_q == pb_q) |->
      ($countones(c0 ^ pop_q[pa_q]) <= 1) && ($countones(c1 ^ pop_q[pa_q]) <= 1));
endmodule

// File: tb/ga_path_engine_test.sv
`timescale 1ns/1ps
module ga_path_engine_test;
  localparam int POP = 8;
  localparam int CW  = 16;
  localparam int DW  = 16;
  localparam int GW  = 8;
  localparam int IW  = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          seed_load_i = 1'b0;
  logic [15:0]   seed_i = '0;
  logic          init_we_i = 1'b0;
  logic [IW-1:0] init_idx_i = '0;
  logic [CW-1:0] init_chrom_i = '0;
  logic          start_i = 1'b0;
  logic [GW-1:0] num_gen_i = '0;
  logic [4:0]    mut_rate_i = '0;
  logic          fit_req_o;
  logic [IW-1:0] fit_idx_o;
  logic [CW-1:0] fit_chrom_o;
  logic          fit_ack_i = 1'b0;
  logic [DW-1:0] fit_dist_i = '0;
  logic          busy_o, done_o;
  logic [CW-1:0] best_chrom_o;
  logic [DW-1:0] best_dist_o;

  ga_path_engine uut (.*);

  always #4 clk_i = ~clk_i;

  int nchk = 0, nfail = 0;
  int dly_cfg = 0, dist_mode = 0, stall_err = 0, nlog = 0;
  logic [CW-1:0] log_c [0:1023];
  int            log_i [0:1023];
  logic [CW-1:0] keep_c [0:1023];
  int            keep_n;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // fitness responder
  initial begin
    forever begin
      @(negedge clk_i);
      if (fit_ack_i) fit_ack_i = 1'b0;
      else if (rst_ni && fit_req_o) begin
        logic [CW-1:0] cc;
        int ci;
        cc = fit_chrom_o;
        ci = int'(fit_idx_o);
        for (int k = 0; k < dly_cfg; k++) begin
          @(negedge clk_i);
          if (!fit_req_o || fit_chrom_o !== cc || int'(fit_idx_o) != ci) stall_err++;
        end
        fit_dist_i = (dist_mode == 1) ? DW'(5) : DW'(cc);
        if (nlog < 1024) begin
          log_c[nlog] = cc;
          log_i[nlog] = ci;
        end
        nlog++;
        fit_ack_i = 1'b1;
      end
    end
  end

  initial begin
    #(8 * 190000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  task automatic load_pop(input logic [CW-1:0] v [POP]);
    for (int i = 0; i < POP; i++) begin
      @(negedge clk_i);
      init_we_i = 1'b1; init_idx_i = IW'(i); init_chrom_i = v[i];
    end
    @(negedge clk_i);
    init_we_i = 1'b0;
  endtask

  task automatic load_seed(input logic [15:0] s);
    @(negedge clk_i);
    seed_load_i = 1'b1; seed_i = s;
    @(negedge clk_i);
    seed_load_i = 1'b0;
  endtask

  task automatic run(input int gens, input logic [4:0] rate);
    int t;
    nlog = 0; stall_err = 0;
    @(negedge clk_i);
    start_i = 1'b1; num_gen_i = GW'(gens); mut_rate_i = rate;
    @(negedge clk_i);
    start_i = 1'b0;
    t = 0;
    while (!done_o && t < 20000) begin
      @(negedge clk_i);
      t++;
    end
    repeat (2) @(negedge clk_i);
  endtask

  task automatic t_reset;
    chk(!busy_o && !done_o && !fit_req_o, "R1", "idle flags", {busy_o, done_o, fit_req_o}, 0);
    chk(best_dist_o == '1, "R1", "best_dist", best_dist_o, 32'hFFFF);
    chk(best_chrom_o == '0, "R1", "best_chrom", best_chrom_o, 0);
  endtask

  task automatic t_single_gen;
    logic [CW-1:0] v [POP];
    bit ok;
    v = '{16'h0300, 16'h0120, 16'h0003, 16'h0700, 16'h4444, 16'h0003, 16'h0911, 16'h8000};
    load_pop(v);
    dly_cfg = 0; dist_mode = 0;
    run(1, 5'd0);
    chk(nlog == POP, "R3", "request count G=1", nlog, POP);
    ok = 1;
    for (int i = 0; i < POP; i++) if (log_i[i] != i || log_c[i] !== v[i]) ok = 0;
    chk(ok, "R2", "ascending loaded members", 0, 0);
    chk(best_dist_o == 16'h0003 && best_chrom_o == 16'h0003, "R4", "min distance",
        {best_chrom_o, best_dist_o}, 32'h00030003);
    chk(done_o && !busy_o, "R8", "done after run", {done_o, busy_o}, 2'b10);
  endtask

  task automatic t_ties;
    dist_mode = 1;
    run(1, 5'd0);
    chk(best_dist_o == 16'd5, "R4", "cleared at start then tie value", best_dist_o, 5);
    chk(best_chrom_o == 16'h0300, "R4", "earliest of equal distances", best_chrom_o, 16'h0300);
    dist_mode = 0;
  endtask

  task automatic t_zero_gen;
    run(0, 5'd0);
    chk(nlog == 0 && done_o && !busy_o, "R3", "G=0 no requests", nlog, 0);
  endtask

  task automatic t_uniform;
    logic [CW-1:0] v [POP];
    bit ok;
    for (int i = 0; i < POP; i++) v[i] = 16'h5A3C;
    load_pop(v);
    dly_cfg = 2;
    run(4, 5'd0);
    chk(nlog == 4 * POP, "R3", "request count G=4", nlog, 4 * POP);
    chk(stall_err == 0, "R3", "request held during stall", stall_err, 0);
    ok = 1;
    for (int i = 0; i < 4 * POP; i++) if (log_c[i] !== 16'h5A3C) ok = 0;
    chk(ok, "R5", "uniform stays uniform", 0, 0);
    dly_cfg = 0;
  endtask

  task automatic t_columns;
    logic [CW-1:0] v [POP];
    bit ok;
    for (int i = 0; i < POP; i++) v[i] = {8'hC3, 8'(i * 37 + 1)};
    load_pop(v);
    load_seed(16'h1D2B);
    run(3, 5'd0);
    ok = 1;
    for (int i = 0; i < 3 * POP; i++) if (log_c[i][15:8] !== 8'hC3) ok = 0;
    chk(ok, "R5", "common byte persists", 0, 0);
  endtask

  task automatic t_mutation;
    logic [CW-1:0] v [POP];
    bit ok;
    for (int i = 0; i < POP; i++) v[i] = 16'h9E01;
    load_pop(v);
    run(2, 5'd16);
    chk(nlog == 2 * POP, "R3", "request count G=2", nlog, 2 * POP);
    ok = 1;
    for (int i = POP; i < 2 * POP; i++) if ($countones(log_c[i] ^ 16'h9E01) != 1) ok = 0;
    chk(ok, "R6", "always-mutate flips one bit", 0, 0);
    chk(ok, "R7", "no original member survives", 0, 0);
  endtask

  task automatic t_seed;
    logic [CW-1:0] v [POP];
    bit ok;
    v = '{16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555, 16'h6666, 16'h7777, 16'h8888};
    load_pop(v); load_seed(16'hBEEF);
    run(3, 5'd8);
    keep_n = nlog;
    for (int i = 0; i < nlog; i++) keep_c[i] = log_c[i];
    load_pop(v); load_seed(16'hBEEF);
    run(3, 5'd8);
    ok = (nlog == keep_n);
    for (int i = 0; i < nlog; i++) if (log_c[i] !== keep_c[i]) ok = 0;
    chk(ok, "R9", "same seed reproduces", nlog, keep_n);
    load_pop(v); load_seed(16'h0001);
    run(3, 5'd8);
    keep_n = nlog;
    for (int i = 0; i < nlog; i++) keep_c[i] = log_c[i];
    load_pop(v); load_seed(16'h0000);
    run(3, 5'd8);
    ok = (nlog == keep_n);
    for (int i = 0; i < nlog; i++) if (log_c[i] !== keep_c[i]) ok = 0;
    chk(ok, "R9", "zero seed acts as 1", nlog, keep_n);
  endtask

  task automatic t_start_busy;
    int t;
    nlog = 0;
    @(negedge clk_i);
    start_i = 1'b1; num_gen_i = GW'(2); mut_rate_i = 5'd4;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o && !done_o, "R8", "busy after start", {busy_o, done_o}, 2'b10);
    repeat (5) @(negedge clk_i);
    start_i = 1'b1; num_gen_i = GW'(5);
    @(negedge clk_i);
    start_i = 1'b0;
    t = 0;
    while (!done_o && t < 20000) begin
      @(negedge clk_i);
      t++;
    end
    repeat (4) @(negedge clk_i);
    chk(nlog == 2 * POP, "R8", "start while busy ignored", nlog, 2 * POP);
    chk(done_o && !busy_o, "R8", "done held", {done_o, busy_o}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_single_gen;
    t_ties;
    t_zero_gen;
    t_uniform;
    t_columns;
    t_mutation;
    t_seed;
    t_start_busy;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule